// File: doc/BRIEF.md
# Full-Scan Binary Counter

A small binary counter whose every state flop carries a two-input select in front of its D pin, so the same flops act either as the counter or as one serial shift register. With the scan select low, each flop captures the functional next state: the count advances by one when the count enable is high and holds otherwise, wrapping from the top value back to zero. With the scan select high, the flops ignore the counter logic and shift one place per clock from the serial input toward the most significant bit.

No state is left outside the chain. The most significant count bit is also the serial output, so the chain needs no extra pin. A test loads a pattern in four shifts, applies one functional clock to capture the next state, and shifts the result out for comparison. The active-low clear is asynchronous and is held inactive while shifting.

Top module: `scan_counter`

## Requirements
- R1: While rst_ni is 0 the count is 0, asynchronously and whatever the value of scan_en_i.
- R2: With scan_en_i at 0 and cnt_en_i at 1, each rising clock edge adds one to count_o.
- R3: An increment from 15 gives 0.
- R4: With scan_en_i at 0 and cnt_en_i at 0, count_o keeps its value across a clock edge.
- R5: With scan_en_i at 1, each rising edge loads scan_in_i into count_o[0] and count_o[i-1] into count_o[i]; the first of four shifted bits ends in count_o[3].
- R6: While scan_en_i is 1, cnt_en_i has no effect on the next state.
- R7: scan_out_o equals count_o[3] at all times.
- R8: After a four-shift load, one functional clock with cnt_en_i at 1 captures the loaded value plus one, and four further shifts present that value on scan_out_o most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active, idle low |
| rst_ni | input | 1 | Asynchronous clear, active low |
| cnt_en_i | input | 1 | Count enable for the functional path |
| scan_en_i | input | 1 | 1 selects serial shifting, 0 selects counting |
| scan_in_i | input | 1 | Serial data entering bit 0 |
| count_o | output | 4 | Counter state |
| scan_out_o | output | 1 | Serial output, same net as count_o[3] |

## Verification
The hardest state to reach is a mid-chain value that the counter path would never produce from the current count, followed by a single functional capture and an unload; the stimulus gets there by shifting an arbitrary pattern with cnt_en_i toggling, then capturing, then reading scan_out_o on four shifts. A clear asserted in the middle of a shift sequence is also driven, between clock edges, to show the asynchronous path wins over scan mode.

// File: rtl/scan_cnt_pkg.sv
package scan_cnt_pkg;
  parameter int unsigned CNT_W = 4;

  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_SHIFT = 1'b1
  } ff_mode_e;
endpackage

// File: rtl/cnt_next.sv
module cnt_next #(
  parameter int unsigned W = scan_cnt_pkg::CNT_W
) (
  input  logic [W-1:0] q_i,
  input  logic         en_i,
  output logic [W-1:0] d_o
);
  // wraps naturally by truncation
  always_comb d_o = en_i ? q_i + W'(1) : q_i;
endmodule

// File: rtl/scan_mux_ff.sv
module scan_mux_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  scan_cnt_pkg::ff_mode_e mode_i,
  input  logic func_d_i,
  input  logic scan_d_i,
  output logic q_o
);
  logic d_sel;

  always_comb d_sel = (mode_i == scan_cnt_pkg::MODE_SHIFT) ? scan_d_i : func_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_sel;
  end
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int unsigned W = scan_cnt_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         scan_en_i,
  input  logic         scan_in_i,
  output logic [W-1:0] count_o,
  output logic         scan_out_o
);
  import scan_cnt_pkg::*;

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] q;
  logic [W-1:0] func_d;
  logic [W-1:0] chain_d;
  ff_mode_e     mode;

  always_comb mode = scan_en_i ? MODE_SHIFT : MODE_FUNC;

  cnt_next #(.W(W)) u_next (
    .q_i  (q),
    .en_i (cnt_en_i),
    .d_o  (func_d)
  );

  // chain runs bit 0 -> bit MSB
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      if (gi == 0) begin : g_head
        always_comb chain_d[gi] = scan_in_i;
      end else begin : g_link
        always_comb chain_d[gi] = q[gi-1];
      end
      scan_mux_ff u_ff (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode),
        .func_d_i (func_d[gi]),
        .scan_d_i (chain_d[gi]),
        .q_o      (q[gi])
      );
    end
  endgenerate

  assign count_o    = q;
  assign scan_out_o = q[MSB];

  p_clear_r1: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);

  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && cnt_en_i) |=> count_o == W'($past(count_o) + W'(1)));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && cnt_en_i && count_o == '1) |=> count_o == '0);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && !cnt_en_i) |=> $stable(count_o));

  p_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> (count_o[0] == $past(scan_in_i)) &&
                  (count_o[MSB:1] == $past(count_o[MSB-1:0])));
endmodule

// File: tb/sim_scan_counter.sv
module sim_scan_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cnt_en_i = 1'b0;
  logic       scan_en_i = 1'b0;
  logic       scan_in_i = 1'b0;
  logic [3:0] count_o;
  logic       scan_out_o;

  int checks = 0;
  int failures = 0;
  int model = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  scan_counter u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i),
    .scan_en_i(scan_en_i), .scan_in_i(scan_in_i),
    .count_o(count_o), .scan_out_o(scan_out_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit en, input bit sen, input bit sin, input string tag);
    cnt_en_i = en; scan_en_i = sen; scan_in_i = sin;
    @(posedge clk_i);
    if (sen) model = ((model << 1) | int'(sin)) & 15;
    else if (en) model = (model + 1) % 16;
    @(negedge clk_i);
    check(tag, int'(count_o), model);
    check("R7", int'(scan_out_o), (model >> 3) & 1);
  endtask

  initial begin
    automatic int serial = 0;
    repeat (3) @(negedge clk_i);
    check("R1", int'(count_o), 0);
    scan_en_i = 1'b1; scan_in_i = 1'b1;
    @(negedge clk_i);
    check("R1", int'(count_o), 0);
    scan_en_i = 1'b0;
    rst_ni = 1'b1;
    // count through a wrap
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, (model == 15) ? "R3" : "R2");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R4");
    // load 1,0,1,1 with count enable toggling
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, "R5");
    check("R5", int'(count_o), 4'b1011);
    step(1'b1, 1'b0, 1'b0, "R8");
    check("R8", int'(count_o), 4'b1100);
    for (int i = 0; i < 4; i++) begin
      serial = (serial << 1) | int'(scan_out_o);
      step(1'b1, 1'b1, 1'b0, "R5");
    end
    check("R8", serial, 4'b1100);
    check("R5", int'(count_o), 0);
    // reload, then clear mid-shift between edges
    step(1'b0, 1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b1, "R5");
    step(1'b0, 1'b0, 1'b0, "R4");
    check("R5", int'(count_o), 3);
    scan_en_i = 1'b1; scan_in_i = 1'b1;
    #3 rst_ni = 1'b0;
    #2 check("R1", int'(count_o), 0);
    model = 0;
    @(negedge clk_i);
    check("R1", int'(count_o), 0);
    rst_ni = 1'b1;
    // wrap from loaded 15
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, "R3");
    check("R3", int'(count_o), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule